// File: doc/BRIEF.md
# Selectable Signed/Unsigned Magnitude Comparator

This block orders two equal-width operands and reports whether the first is greater than, equal to, or less than the second. A single mode input picks the number system. When it is low, both operands are read as unsigned binary. When it is high, both are read as two's-complement signed integers. The block has no clock and no stored state. Its three flags follow the operands and the mode through combinational logic only.

The unsigned ordering comes from a two-level parallel tree. The first level splits the operands into 4-bit groups, and each group feeds its own small comparator cell. The second level is a priority compare across the group flags: the most significant group that is not equal decides the result. A parameter picks how each cell is built. The two choices are a minimised sum-of-products form and a ripple chain of cascadable one-bit slices. Both choices must give identical flags.

A small sign-control stage looks only at the two most significant bits and the mode. It drives a strobe struct into the datapath. The strobes either force the result when the sign bits differ in signed mode, or let the tree result through unchanged.

Top module: `sel_cmp`

## Requirements
- R1: Exactly one of `aGt`, `aEq`, `aLt` is high for every combination of `opA`, `opB` and `signedMode`.
- R2: With `signedMode` = 0, the flags follow the unsigned binary values of `opA` and `opB`.
- R3: With `signedMode` = 1, the flags follow the two's-complement values of `opA` and `opB`. Bit WIDTH-1 is the sign bit.
- R4: With `signedMode` = 1 and differing sign bits, the operand whose bit WIDTH-1 is 0 is reported greater, whatever its lower bits are.
- R5: With `signedMode` = 1 and equal sign bits, the flags are the same as with `signedMode` = 0 for the same operands.
- R6: `aEq` is high exactly when `opA` and `opB` are bit-for-bit identical, in either mode.
- R7: The flags are identical for `CELL_STYLE` = 0 (equation cells) and `CELL_STYLE` = 1 (ripple cells) for every input.
- R8: At the extremes, 16'h7FFF against 16'h8000 gives `aGt` in signed mode and `aLt` in unsigned mode. Small negatives such as -5 and -22 are ordered below zero, and -22 is below -5.
- R9: The flags depend only on the present inputs. They settle within 2 ns of simulated time after an input change, and no clock edge is involved.
- R10: Any `WIDTH` that is a multiple of `CELL_W` orders correctly. An 8-bit build is covered over every operand pair in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, compared against opB |
| opB | input | WIDTH | Second operand |
| signedMode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| aGt | output | 1 | opA is greater than opB |
| aEq | output | 1 | opA equals opB |
| aLt | output | 1 | opA is less than opB |

## Verification
Every result of this block is due zero cycles after its stimulus. Through the tree and the sign-control stage, each flag is a combinational function of the present operands and mode. For that reason the bench never counts clock edges for a result. It drives a new pair and mode, waits 2 ns so the combinational paths can settle, and samples all three flags. It then holds the inputs for 2 ns more before it applies the next pair, so no sample sees a half-changed input.

// File: rtl/selcmp_pkg.sv
package selcmp_pkg;

  // Three-way ordering result
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } ordFlags_t;

  // Strobes from sign control into the magnitude datapath
  typedef struct packed {
    logic forceGt;
    logic forceLt;
    logic passTree;
  } signStrobe_t;

  localparam int CELL_EQUATIONS = 0;
  localparam int CELL_RIPPLE    = 1;

endpackage

// File: rtl/cmpBitSlice.sv
module cmpBitSlice (
  input  logic aBit,
  input  logic bBit,
  input  logic gtIn,
  input  logic ltIn,
  output logic gtOut,
  output logic ltOut
);
  logic same;

  // This bit decides unless it matches; a match passes the lower verdict up
  always_comb begin
    same  = ~(aBit ^ bBit);
    gtOut = (aBit & ~bBit) | (same & gtIn);
    ltOut = (~aBit & bBit) | (same & ltIn);
  end
endmodule

// File: rtl/cmpCell.sv
module cmpCell
  import selcmp_pkg::*;
#(
  parameter int CELL_W     = 4,
  parameter int CELL_STYLE = CELL_EQUATIONS
) (
  input  logic [CELL_W-1:0] aNib,
  input  logic [CELL_W-1:0] bNib,
  output ordFlags_t         flags
);

  generate
    if (CELL_STYLE == CELL_RIPPLE) begin : g_ripple
      logic [CELL_W:0] gtChain;
      logic [CELL_W:0] ltChain;
      assign gtChain[0] = 1'b0;
      assign ltChain[0] = 1'b0;
      for (genvar i = 0; i < CELL_W; i++) begin : g_slice
        cmpBitSlice u_slice (
          .aBit (aNib[i]),
          .bBit (bNib[i]),
          .gtIn (gtChain[i]),
          .ltIn (ltChain[i]),
          .gtOut(gtChain[i+1]),
          .ltOut(ltChain[i+1])
        );
      end
      always_comb begin
        flags.gt = gtChain[CELL_W];
        flags.lt = ltChain[CELL_W];
        flags.eq = ~gtChain[CELL_W] & ~ltChain[CELL_W];
      end
    end else begin : g_equations
      logic [CELL_W-1:0] bitSame;
      logic              upperSame;
      logic              gtAcc;
      logic              ltAcc;
      // Flat sum of products: bit i counts only when every higher bit matches
      always_comb begin
        bitSame   = ~(aNib ^ bNib);
        upperSame = 1'b1;
        gtAcc     = 1'b0;
        ltAcc     = 1'b0;
        for (int i = CELL_W - 1; i >= 0; i--) begin
          gtAcc     = gtAcc | (upperSame & aNib[i] & ~bNib[i]);
          ltAcc     = ltAcc | (upperSame & ~aNib[i] & bNib[i]);
          upperSame = upperSame & bitSame[i];
        end
        flags.gt = gtAcc;
        flags.lt = ltAcc;
        flags.eq = &bitSame;
      end
    end
  endgenerate

endmodule

// File: rtl/cmpSignCtl.sv
module cmpSignCtl
  import selcmp_pkg::*;
(
  input  logic        signedMode,
  input  logic        signA,
  input  logic        signB,
  output signStrobe_t strobe
);
  logic splitSigns;

  always_comb begin
    splitSigns      = signedMode & (signA ^ signB);
    strobe.passTree = ~splitSigns;
    strobe.forceGt  = splitSigns & ~signA;
    strobe.forceLt  = splitSigns & signA;
  end
endmodule

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import selcmp_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int CELL_W     = 4,
  parameter int CELL_STYLE = CELL_EQUATIONS
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  signStrobe_t      strobe,
  output ordFlags_t        result
);
  localparam int NCELL = WIDTH / CELL_W;

  ordFlags_t cellFlags [NCELL];
  ordFlags_t treeFlags;

  // First level: one comparator cell per group
  generate
    for (genvar c = 0; c < NCELL; c++) begin : g_cell
      cmpCell #(
        .CELL_W    (CELL_W),
        .CELL_STYLE(CELL_STYLE)
      ) u_cell (
        .aNib (opA[c*CELL_W +: CELL_W]),
        .bNib (opB[c*CELL_W +: CELL_W]),
        .flags(cellFlags[c])
      );
    end
  endgenerate

  // Second level: a parallel priority compare over the group flags
  always_comb begin
    logic upperEq;
    upperEq      = 1'b1;
    treeFlags.gt = 1'b0;
    treeFlags.lt = 1'b0;
    for (int c = NCELL - 1; c >= 0; c--) begin
      treeFlags.gt = treeFlags.gt | (upperEq & cellFlags[c].gt);
      treeFlags.lt = treeFlags.lt | (upperEq & cellFlags[c].lt);
      upperEq      = upperEq & cellFlags[c].eq;
    end
    treeFlags.eq = upperEq;
  end

  // Final merge: sign strobes override the tree verdict
  always_comb begin
    result = treeFlags;
    if (!strobe.passTree) begin
      result.gt = strobe.forceGt;
      result.lt = strobe.forceLt;
      result.eq = 1'b0;
    end
  end
endmodule

// File: rtl/sel_cmp.sv
module sel_cmp
  import selcmp_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int CELL_W     = 4,
  parameter int CELL_STYLE = CELL_EQUATIONS
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             signedMode,
  output logic             aGt,
  output logic             aEq,
  output logic             aLt
);
  signStrobe_t strobe;
  ordFlags_t   result;

  cmpSignCtl u_ctl (
    .signedMode(signedMode),
    .signA     (opA[WIDTH-1]),
    .signB     (opB[WIDTH-1]),
    .strobe    (strobe)
  );

  cmpDatapath #(
    .WIDTH     (WIDTH),
    .CELL_W    (CELL_W),
    .CELL_STYLE(CELL_STYLE)
  ) u_dp (
    .opA   (opA),
    .opB   (opB),
    .strobe(strobe),
    .result(result)
  );

  assign aGt = result.gt;
  assign aEq = result.eq;
  assign aLt = result.lt;
endmodule

// File: rtl/sel_cmp_chk.sv
module sel_cmp_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             signedMode,
  input logic             aGt,
  input logic             aEq,
  input logic             aLt
);
  always_comb begin
    if (!$isunknown({opA, opB, signedMode, aGt, aEq, aLt})) begin
      a_r1_onehot_flags: assert ($onehot({aGt, aEq, aLt}))
        else $error("R1 flags not one-hot");
      a_r6_eq_identical: assert (aEq == (opA == opB))
        else $error("R6 equal flag wrong");
      a_r2_unsigned_order: assert (signedMode || (aGt == (opA > opB)))
        else $error("R2 unsigned ordering wrong");
      a_r3_signed_order: assert (!signedMode || (aLt == ($signed(opA) < $signed(opB))))
        else $error("R3 signed ordering wrong");
      a_r4_sign_split: assert (!(signedMode && (opA[WIDTH-1] != opB[WIDTH-1]))
                               || (aGt == !opA[WIDTH-1]))
        else $error("R4 split-sign verdict wrong");
    end
  end
endmodule

bind sel_cmp sel_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .opA       (opA),
  .opB       (opB),
  .signedMode(signedMode),
  .aGt       (aGt),
  .aEq       (aEq),
  .aLt       (aLt)
);

// File: tb/sim_sel_cmp.sv
`timescale 1ns/1ps
module sim_sel_cmp;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int compared   = 0;
  int mismatched = 0;
  logic done     = 1'b0;

  logic [15:0] a16, b16;
  logic [7:0]  a8, b8;
  logic        mode;
  logic g0, e0, l0, g1, e1, l1, g2, e2, l2, g3, e3, l3;

  sel_cmp #(.WIDTH(16), .CELL_W(4), .CELL_STYLE(0)) u0 (
    .opA(a16), .opB(b16), .signedMode(mode), .aGt(g0), .aEq(e0), .aLt(l0));
  sel_cmp #(.WIDTH(16), .CELL_W(4), .CELL_STYLE(1)) u1 (
    .opA(a16), .opB(b16), .signedMode(mode), .aGt(g1), .aEq(e1), .aLt(l1));
  sel_cmp #(.WIDTH(8), .CELL_W(4), .CELL_STYLE(0)) u2 (
    .opA(a8), .opB(b8), .signedMode(mode), .aGt(g2), .aEq(e2), .aLt(l2));
  sel_cmp #(.WIDTH(8), .CELL_W(4), .CELL_STYLE(1)) u3 (
    .opA(a8), .opB(b8), .signedMode(mode), .aGt(g3), .aEq(e3), .aLt(l3));

  // Expected {gt,eq,lt} computed arithmetically from the operand values
  function automatic logic [2:0] expect3(input int av, input int bv, input int w, input logic m);
    int x, y;
    x = av; y = bv;
    if (m && x >= (1 << (w - 1))) x = x - (1 << w);
    if (m && y >= (1 << (w - 1))) y = y - (1 << w);
    if (x > y)       return 3'b100;
    else if (x == y) return 3'b010;
    else             return 3'b001;
  endfunction

  function automatic string tagFor(input int av, input int bv, input int w, input logic m);
    if (av == bv) return "R6";
    if (m && ((av >> (w - 1)) != (bv >> (w - 1)))) return "R4";
    if (m) return "R5";
    return "R2";
  endfunction

  task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b (a16=%h b16=%h a8=%h b8=%h mode=%b)",
               req, act, exp, a16, b16, a8, b8, mode);
    end
  endtask

  // Drive a 16-bit pair, let it settle, sample, then hold
  task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic m, input string extra);
    logic [2:0] exp;
    a16 = a; b16 = b; mode = m;
    #2;
    exp = expect3(int'(a), int'(b), 16, m);
    check3(extra.len() > 0 ? extra : (m ? "R3" : "R2"), {g0, e0, l0}, exp);
    check3(tagFor(int'(a), int'(b), 16, m), {g1, e1, l1}, exp);
    check3("R7", {g1, e1, l1}, {g0, e0, l0});
    check3("R1", {2'b00, $onehot({g0, e0, l0})}, 3'b001);
    #2;
  endtask

  int vecs [16] = '{32760, 18841, -30504, -22, 18340, -13740, 0, 31220,
                    -31554, 22780, -19306, 12408, -5, 0, -5545, 15554};

  initial begin
    a16 = '0; b16 = '0; a8 = '0; b8 = '0; mode = 1'b0;
    #2;
    // Equal operands after start-up: only aEq raised
    check3("R6", {g0, e0, l0}, 3'b010);
    check3("R6", {g2, e2, l2}, 3'b010);
    #3;

    // R8 extremes and small negatives
    run16(16'h7FFF, 16'h8000, 1'b1, "R8");
    run16(16'h7FFF, 16'h8000, 1'b0, "R8");
    run16(16'hFFFB, 16'h0000, 1'b1, "R8");
    run16(16'hFFEA, 16'hFFFB, 1'b1, "R8");
    run16(16'h8000, 16'h8000, 1'b1, "R6");
    run16(16'h7FF8, 16'h88D8, 1'b1, "R4");

    // Directed pairs in both modes, every ordering of the listed values
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int m = 0; m < 2; m++)
          run16(16'(vecs[i]), 16'(vecs[j]), m[0], "");

    // R9: reapply a pair after others; result depends only on present inputs
    run16(16'h1234, 16'h1233, 1'b0, "R9");
    run16(16'hF000, 16'h0FFF, 1'b1, "R9");
    run16(16'h1234, 16'h1233, 1'b0, "R9");

    // Random 16-bit pairs; some share high groups to exercise the lower ones
    for (int k = 0; k < 6000; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (k % 3 == 1) rb[15:8] = ra[15:8];
      if (k % 3 == 2) rb[15:4] = ra[15:4];
      run16(ra, rb, k[0], "");
    end

    // R10: exhaustive 8-bit sweep, both modes, both cell styles (R7)
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++) begin
          logic [2:0] exp;
          a8 = 8'(x); b8 = 8'(y); mode = m[0];
          #2;
          exp = expect3(x, y, 8, m[0]);
          check3("R10", {g2, e2, l2}, exp);
          if ({g3, e3, l3} !== {g2, e2, l2}) check3("R7", {g3, e3, l3}, {g2, e2, l2});
          else compared++;
          #2;
        end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule